// File: doc/BRIEF.md
# Mapping command field decoder

This block serves a command queue consumer. It handles the two commands that install mappings: a collection-to-processor binding and a device-to-translation-table binding. The consumer hands over the opcode, the byte offset of the 32-byte queue entry and the first 64-bit word of that entry. The decoder then fetches the other words it needs through a 64-bit read port, one request at a time. It pulls out the fields and checks them against the live limit inputs. When the command is accepted it sends one packed entry to the table writer. It then reports completion with a success flag.

When a range check rejects a command, the decoder still reports success and writes nothing, so the consumer moves past the entry. A read error reports failure, and the consumer is expected to stall on it. An opcode that is neither mapping command completes at once with success. It fetches nothing and updates nothing.

Top module: `mapcmd_decoder`

## Requirements
- R1: After reset the block is idle: `disp_ready` is 1 and `rd_req_valid`, `upd_valid` and `done_valid` are 0.
- R2: Opcode 0x08 is the device mapping and opcode 0x09 is the collection mapping. A collection mapping issues exactly one read, at entry offset + 16. A device mapping issues a read at offset + 8 and then one at offset + 16. The second read is issued only after the first response. Address arithmetic wraps modulo 2^OFF_W.
- R3: For a collection mapping, the collection ID is word2[15:0], the target is word2[31:16] and the valid flag is word2[63]. On acceptance, `upd_is_dev`=0 and `upd_index` is the collection ID. `upd_entry` bit 0 is the valid flag, bits [16:1] hold the target and all other bits are 0. When the valid flag is 0, the whole entry is 0.
- R4: For a device mapping, the device ID is word0[63:32], the size is word1[4:0], the table address is word2[51:8] and the valid flag is word2[63]. On acceptance, `upd_is_dev`=1 and `upd_index` is the device ID. `upd_entry` bit 0 is the valid flag, bits [5:1] hold the size, bits [49:6] hold the table address and all other bits are 0. When the valid flag is 0, the whole entry is 0.
- R5: A collection mapping whose ID is above `cfg_max_coll`, or whose target is above `cfg_cpu_count`, completes with `done_ok`=1 and no update. Values equal to the limits are accepted.
- R6: A device mapping whose ID is above `cfg_max_dev`, or whose size is above `cfg_id_bits`, completes with `done_ok`=1 and no update. Values equal to the limits are accepted.
- R7: A read response with `rd_rsp_err`=1 ends the command at once. The command completes with `done_ok`=0, with no further read and no update.
- R8: Any other opcode completes in the first cycle after acceptance with `done_ok`=1, no read and no update.
- R9: Each accepted dispatch gives exactly one `done_valid` pulse. For a mapping command, that pulse comes one cycle after its last read response. `disp_ready` is 0 from acceptance until the cycle after `done_valid`. `upd_valid` is asserted only together with `done_valid` and `done_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offered |
| disp_ready | output | 1 | Decoder idle; a dispatch is taken when both are high |
| disp_opcode | input | 8 | Command opcode |
| disp_offset | input | OFF_W | Byte offset of the queue entry |
| disp_dw0 | input | 64 | First word of the entry |
| rd_req_valid | output | 1 | One-cycle read request |
| rd_req_addr | output | OFF_W | Byte offset to read |
| rd_rsp_valid | input | 1 | Read response, at least one cycle after the request |
| rd_rsp_data | input | 64 | Read data |
| rd_rsp_err | input | 1 | Read failed |
| cfg_max_coll | input | ICID_W | Largest legal collection ID |
| cfg_cpu_count | input | PROC_W | Largest legal target number |
| cfg_max_dev | input | DEV_W | Largest legal device ID |
| cfg_id_bits | input | SIZE_W | Largest legal size field |
| upd_valid | output | 1 | Table update request |
| upd_is_dev | output | 1 | 1 for the device table, 0 for the collection table |
| upd_index | output | IDX_W | Table index |
| upd_entry | output | 64 | Packed table entry |
| done_valid | output | 1 | Command finished |
| done_ok | output | 1 | 1 for success, 0 for a read error |

## Verification
Collection mappings are tried with in-range fields, with fields exactly at the limits and with fields one step past each limit. Together these separate an off-by-one comparison from a correct one. Device mappings carry junk in the bits that must be ignored, which exposes wrong field slicing. They also run once with the valid flag cleared, to show that the whole entry is zeroed. Read errors are injected on the first fetch and on the second fetch, to show that the command stops early and reports failure. An entry near the top of the offset space checks the address wrap. A non-mapping opcode and varied response latencies check the completion timing and the one-request-at-a-time ordering.

// File: rtl/mapdec_pkg.sv
package mapdec_pkg;
   localparam int unsigned DW_W = 64;
   localparam logic [7:0] OP_MAP_DEV  = 8'h08;
   localparam logic [7:0] OP_MAP_COLL = 8'h09;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_REQ,
      SQ_WAIT,
      SQ_FIN
   } seq_state_e;

   typedef struct packed {
      logic coll;
      logic dev;
   } cmd_kind_t;
endpackage

// File: rtl/mapdec_fetch_seq.sv
module mapdec_fetch_seq
   import mapdec_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_map,
   input  logic want_lo,
   input  logic rsp_valid,
   input  logic rsp_err,
   output logic idle,
   output logic req_valid,
   output logic req_hi,
   output logic cap_lo,
   output logic cap_hi,
   output logic fin,
   output logic failed
);
   seq_state_e st_q;
   logic       hi_q;
   logic       err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         hi_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  err_q <= 1'b0;
                  hi_q  <= !want_lo;
                  st_q  <= is_map ? SQ_REQ : SQ_FIN;
               end
            end
            SQ_REQ: st_q <= SQ_WAIT;
            SQ_WAIT: begin
               if (rsp_valid) begin
                  if (rsp_err) begin
                     err_q <= 1'b1;
                     st_q  <= SQ_FIN;
                  end else if (!hi_q) begin
                     hi_q <= 1'b1;
                     st_q <= SQ_REQ;
                  end else begin
                     st_q <= SQ_FIN;
                  end
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign idle      = (st_q == SQ_IDLE);
   assign req_valid = (st_q == SQ_REQ);
   assign req_hi    = hi_q;
   assign cap_lo    = (st_q == SQ_WAIT) && rsp_valid && !rsp_err && !hi_q;
   assign cap_hi    = (st_q == SQ_WAIT) && rsp_valid && !rsp_err && hi_q;
   assign fin       = (st_q == SQ_FIN);
   assign failed    = err_q;
endmodule

// File: rtl/mapdec_field_unpack.sv
module mapdec_field_unpack
   import mapdec_pkg::*;
#(
   parameter int unsigned ICID_W = 16,
   parameter int unsigned PROC_W = 16,
   parameter int unsigned DEV_W  = 32,
   parameter int unsigned SIZE_W = 5,
   parameter int unsigned ITT_W  = 44,
   parameter int unsigned IDX_W  = 32,
   parameter int unsigned BODY_W = 52
)(
   input  logic              sel_dev,
   input  logic [DEV_W-1:0]  dev_id,
   input  logic [SIZE_W-1:0] dev_size,
   input  logic [BODY_W-1:0] body,
   input  logic              ent_valid,
   input  logic [ICID_W-1:0] cfg_max_coll,
   input  logic [PROC_W-1:0] cfg_cpu_count,
   input  logic [DEV_W-1:0]  cfg_max_dev,
   input  logic [SIZE_W-1:0] cfg_id_bits,
   output logic              in_range,
   output logic [IDX_W-1:0]  index,
   output logic [DW_W-1:0]   entry
);
   localparam int unsigned TGT_LSB = 16;
   localparam int unsigned ITT_LSB = 8;

   logic [ICID_W-1:0] coll_id;
   logic [PROC_W-1:0] target;
   logic [ITT_W-1:0]  itt_addr;
   logic              coll_ok;
   logic              dev_ok;
   logic [DW_W-1:0]   coll_entry;
   logic [DW_W-1:0]   dev_entry;

   assign coll_id  = body[ICID_W-1:0];
   assign target   = body[TGT_LSB +: PROC_W];
   assign itt_addr = body[ITT_LSB +: ITT_W];

   assign coll_ok = (coll_id <= cfg_max_coll) && (target <= cfg_cpu_count);
   assign dev_ok  = (dev_id <= cfg_max_dev) && (dev_size <= cfg_id_bits);

   assign coll_entry = ent_valid ? DW_W'({target, 1'b1}) : '0;
   assign dev_entry  = ent_valid ? DW_W'({itt_addr, dev_size, 1'b1}) : '0;

   always_comb begin
      if (sel_dev) begin
         in_range = dev_ok;
         index    = IDX_W'(dev_id);
         entry    = dev_entry;
      end else begin
         in_range = coll_ok;
         index    = IDX_W'(coll_id);
         entry    = coll_entry;
      end
   end
endmodule

// File: rtl/mapcmd_decoder.sv
module mapcmd_decoder
   import mapdec_pkg::*;
#(
   parameter int unsigned OFF_W  = 20,
   parameter int unsigned ICID_W = 16,
   parameter int unsigned PROC_W = 16,
   parameter int unsigned DEV_W  = 32,
   parameter int unsigned SIZE_W = 5,
   parameter int unsigned ITT_W  = 44,
   localparam int unsigned IDX_W = (DEV_W > ICID_W) ? DEV_W : ICID_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   output logic              disp_ready,
   input  logic [7:0]        disp_opcode,
   input  logic [OFF_W-1:0]  disp_offset,
   input  logic [63:0]       disp_dw0,
   output logic              rd_req_valid,
   output logic [OFF_W-1:0]  rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [63:0]       rd_rsp_data,
   input  logic              rd_rsp_err,
   input  logic [ICID_W-1:0] cfg_max_coll,
   input  logic [PROC_W-1:0] cfg_cpu_count,
   input  logic [DEV_W-1:0]  cfg_max_dev,
   input  logic [SIZE_W-1:0] cfg_id_bits,
   output logic              upd_valid,
   output logic              upd_is_dev,
   output logic [IDX_W-1:0]  upd_index,
   output logic [63:0]       upd_entry,
   output logic              done_valid,
   output logic              done_ok
);
   localparam int unsigned TGT_END = 16 + PROC_W;
   localparam int unsigned ITT_END = 8 + ITT_W;
   localparam int unsigned BODY_W  = (TGT_END > ITT_END) ? TGT_END : ITT_END;
   localparam int unsigned DEVID_LSB = 32;

   generate
      if (OFF_W < 6)             begin : g_bad_off  $error("OFF_W too small for 32-byte entries"); end
      if (ICID_W > 16)           begin : g_bad_icid $error("ICID_W overlaps the target field"); end
      if (DEV_W > 32)            begin : g_bad_dev  $error("DEV_W exceeds the upper word half"); end
      if (BODY_W > DW_W - 1)     begin : g_bad_body $error("fields overlap the valid flag"); end
      if (1 + PROC_W > DW_W)     begin : g_bad_proc $error("target does not fit the entry"); end
      if (6 + ITT_W > DW_W)      begin : g_bad_itt  $error("table address does not fit the entry"); end
      if (SIZE_W != 5)           begin : g_bad_size $error("size field packing assumes 5 bits"); end
   endgenerate

   cmd_kind_t          kind_q;
   logic [OFF_W-1:0]   off_q;
   logic [DEV_W-1:0]   devid_q;
   logic [SIZE_W-1:0]  size_q;
   logic [BODY_W-1:0]  body_q;
   logic               vld_q;

   logic accept;
   logic is_dev_op;
   logic is_coll_op;
   logic sq_idle, sq_req, sq_hi, sq_cap_lo, sq_cap_hi, sq_fin, sq_failed;
   logic in_range;
   logic [IDX_W-1:0] idx_w;
   logic [DW_W-1:0]  entry_w;
   logic input_unused;

   assign is_dev_op  = (disp_opcode == OP_MAP_DEV);
   assign is_coll_op = (disp_opcode == OP_MAP_COLL);
   assign accept     = disp_valid && sq_idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= '0;
         off_q   <= '0;
         devid_q <= '0;
         size_q  <= '0;
         body_q  <= '0;
         vld_q   <= 1'b0;
      end else begin
         if (accept) begin
            kind_q.dev  <= is_dev_op;
            kind_q.coll <= is_coll_op;
            off_q       <= disp_offset;
            devid_q     <= disp_dw0[DEVID_LSB +: DEV_W];
         end
         if (sq_cap_lo) begin
            size_q <= rd_rsp_data[SIZE_W-1:0];
         end
         if (sq_cap_hi) begin
            body_q <= rd_rsp_data[BODY_W-1:0];
            vld_q  <= rd_rsp_data[DW_W-1];
         end
      end
   end

   mapdec_fetch_seq seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .is_map    (is_dev_op || is_coll_op),
      .want_lo   (is_dev_op),
      .rsp_valid (rd_rsp_valid),
      .rsp_err   (rd_rsp_err),
      .idle      (sq_idle),
      .req_valid (sq_req),
      .req_hi    (sq_hi),
      .cap_lo    (sq_cap_lo),
      .cap_hi    (sq_cap_hi),
      .fin       (sq_fin),
      .failed    (sq_failed)
   );

   mapdec_field_unpack #(
      .ICID_W (ICID_W),
      .PROC_W (PROC_W),
      .DEV_W  (DEV_W),
      .SIZE_W (SIZE_W),
      .ITT_W  (ITT_W),
      .IDX_W  (IDX_W),
      .BODY_W (BODY_W)
   ) unpack_i (
      .sel_dev       (kind_q.dev),
      .dev_id        (devid_q),
      .dev_size      (size_q),
      .body          (body_q),
      .ent_valid     (vld_q),
      .cfg_max_coll  (cfg_max_coll),
      .cfg_cpu_count (cfg_cpu_count),
      .cfg_max_dev   (cfg_max_dev),
      .cfg_id_bits   (cfg_id_bits),
      .in_range      (in_range),
      .index         (idx_w),
      .entry         (entry_w)
   );

   assign input_unused = ^{disp_dw0, rd_rsp_data};

   assign disp_ready   = sq_idle;
   assign rd_req_valid = sq_req;
   assign rd_req_addr  = off_q + (sq_hi ? OFF_W'(16) : OFF_W'(8));
   assign done_valid   = sq_fin;
   assign done_ok      = !sq_failed;
   assign upd_valid    = sq_fin && !sq_failed && (kind_q.dev || kind_q.coll) && in_range;
   assign upd_is_dev   = kind_q.dev;
   assign upd_index    = idx_w;
   assign upd_entry    = entry_w;
endmodule

// File: rtl/mapcmd_decoder_chk.sv
module mapcmd_decoder_chk #(
   parameter int unsigned ICID_W = 16,
   parameter int unsigned PROC_W = 16,
   parameter int unsigned DEV_W  = 32,
   parameter int unsigned SIZE_W = 5,
   parameter int unsigned IDX_W  = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              disp_ready,
   input logic              rd_req_valid,
   input logic              rd_rsp_valid,
   input logic              rd_rsp_err,
   input logic [ICID_W-1:0] cfg_max_coll,
   input logic [PROC_W-1:0] cfg_cpu_count,
   input logic [DEV_W-1:0]  cfg_max_dev,
   input logic [SIZE_W-1:0] cfg_id_bits,
   input logic              upd_valid,
   input logic              upd_is_dev,
   input logic [IDX_W-1:0]  upd_index,
   input logic [63:0]       upd_entry,
   input logic              done_valid,
   input logic              done_ok
);
   // R2: requests are issued one at a time, never back to back
   a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |=> !rd_req_valid);

   // R9: busy while a fetch is in flight
   a_r9_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> !disp_ready);

   // R9: update only with a successful completion
   a_r9_upd_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (done_valid && done_ok));

   // R9: idle again after completion
   a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> disp_ready);

   // R7: an erroring response ends the command with failure
   a_r7_err_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rsp_valid && rd_rsp_err && !disp_ready && !done_valid) |=> (done_valid && !done_ok));

   // R5: collection updates stay inside the limits
   a_r5_coll_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_is_dev) |->
         ((upd_index <= IDX_W'(cfg_max_coll)) && (upd_entry[PROC_W:1] <= cfg_cpu_count)));

   // R6: device updates stay inside the limits
   a_r6_dev_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_is_dev) |->
         ((upd_index <= IDX_W'(cfg_max_dev)) && (upd_entry[SIZE_W:1] <= cfg_id_bits)));

   // R3 / R4: an invalid mapping carries an all-zero entry
   a_r3_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_entry[0]) |-> (upd_entry == 64'd0));
endmodule

bind mapcmd_decoder mapcmd_decoder_chk #(
   .ICID_W (ICID_W),
   .PROC_W (PROC_W),
   .DEV_W  (DEV_W),
   .SIZE_W (SIZE_W),
   .IDX_W  (IDX_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .disp_ready    (disp_ready),
   .rd_req_valid  (rd_req_valid),
   .rd_rsp_valid  (rd_rsp_valid),
   .rd_rsp_err    (rd_rsp_err),
   .cfg_max_coll  (cfg_max_coll),
   .cfg_cpu_count (cfg_cpu_count),
   .cfg_max_dev   (cfg_max_dev),
   .cfg_id_bits   (cfg_id_bits),
   .upd_valid     (upd_valid),
   .upd_is_dev    (upd_is_dev),
   .upd_index     (upd_index),
   .upd_entry     (upd_entry),
   .done_valid    (done_valid),
   .done_ok       (done_ok)
);

// File: tb/mapcmd_decoder_tb_top.sv
module mapcmd_decoder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int OFF_W = 20;
   localparam logic [OFF_W-1:0] OFF_MASK = '1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              disp_valid = 1'b0;
   logic              disp_ready;
   logic [7:0]        disp_opcode = '0;
   logic [OFF_W-1:0]  disp_offset = '0;
   logic [63:0]       disp_dw0 = '0;
   logic              rd_req_valid;
   logic [OFF_W-1:0]  rd_req_addr;
   logic              rd_rsp_valid = 1'b0;
   logic [63:0]       rd_rsp_data = '0;
   logic              rd_rsp_err = 1'b0;
   logic [15:0]       cfg_max_coll = 16'd100;
   logic [15:0]       cfg_cpu_count = 16'd4;
   logic [31:0]       cfg_max_dev = 32'd1000;
   logic [4:0]        cfg_id_bits = 5'd20;
   logic              upd_valid;
   logic              upd_is_dev;
   logic [31:0]       upd_index;
   logic [63:0]       upd_entry;
   logic              done_valid;
   logic              done_ok;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mapcmd_decoder #(.OFF_W(OFF_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_ready(disp_ready),
      .disp_opcode(disp_opcode), .disp_offset(disp_offset), .disp_dw0(disp_dw0),
      .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
      .cfg_max_coll(cfg_max_coll), .cfg_cpu_count(cfg_cpu_count),
      .cfg_max_dev(cfg_max_dev), .cfg_id_bits(cfg_id_bits),
      .upd_valid(upd_valid), .upd_is_dev(upd_is_dev),
      .upd_index(upd_index), .upd_entry(upd_entry),
      .done_valid(done_valid), .done_ok(done_ok)
   );

   // memory model: two slots per command, anything else errors
   logic [OFF_W-1:0] m_a1, m_a2;
   logic [63:0]      m_d1, m_d2;
   bit               m_e1, m_e2;
   int               m_lat = 0;
   bit               pend = 0;
   int               pcnt = 0;
   logic [OFF_W-1:0] paddr = '0;

   always @(negedge clk) begin
      rd_rsp_valid = 1'b0;
      rd_rsp_err   = 1'b0;
      rd_rsp_data  = '0;
      if (pend) begin
         if (pcnt == 0) begin
            rd_rsp_valid = 1'b1;
            if (paddr == m_a1) begin
               rd_rsp_data = m_d1; rd_rsp_err = m_e1;
            end else if (paddr == m_a2) begin
               rd_rsp_data = m_d2; rd_rsp_err = m_e2;
            end else begin
               rd_rsp_err = 1'b1;
            end
            pend = 0;
         end else begin
            pcnt--;
         end
      end
      if (rst_n && rd_req_valid) begin
         pend  = 1;
         pcnt  = m_lat;
         paddr = rd_req_addr;
      end
   end

   task automatic chk(bit cond, string rq, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic run_cmd(string rq, logic [7:0] op, logic [OFF_W-1:0] off,
                          logic [63:0] dw0, logic [63:0] d1, bit e1,
                          logic [63:0] d2, bit e2, int lat);
      logic [OFF_W-1:0] ea [2];
      int en = 0;
      bit eok = 1;
      bit eupd = 0;
      bit edev = 0;
      logic [31:0] eidx = '0;
      logic [63:0] eent = '0;
      int edone = 0;
      int cyc = 0;
      int nreq = 0;
      bit done = 0;
      bit gotupd = 0;
      logic [31:0] gidx = '0;
      logic [63:0] gent = '0;
      bit gdev = 0;
      bit gok = 0;
      logic [OFF_W-1:0] a1 = (off + OFF_W'(8)) & OFF_MASK;
      logic [OFF_W-1:0] a2 = (off + OFF_W'(16)) & OFF_MASK;

      m_a1 = a1; m_a2 = a2; m_d1 = d1; m_d2 = d2; m_e1 = e1; m_e2 = e2; m_lat = lat;
      ea[0] = '0; ea[1] = '0;
      if (op == 8'h08) begin
         en = 1; ea[0] = a1; edone = lat + 2;
         if (e1) eok = 0;
         else begin
            en = 2; ea[1] = a2; edone += lat + 2;
            if (e2) eok = 0;
            else if (dw0[63:32] <= cfg_max_dev && d1[4:0] <= cfg_id_bits) begin
               eupd = 1; edev = 1; eidx = dw0[63:32];
               eent = d2[63] ? ((64'(d2[51:8]) << 6) | (64'(d1[4:0]) << 1) | 64'd1) : 64'd0;
            end
         end
      end else if (op == 8'h09) begin
         en = 1; ea[0] = a2; edone = lat + 2;
         if (e2) eok = 0;
         else if (d2[15:0] <= cfg_max_coll && d2[31:16] <= cfg_cpu_count) begin
            eupd = 1; edev = 0; eidx = 32'(d2[15:0]);
            eent = d2[63] ? ((64'(d2[31:16]) << 1) | 64'd1) : 64'd0;
         end
      end

      @(negedge clk);
      chk(disp_ready == 1'b1, "R9", "ready before dispatch", 64'(disp_ready), 64'd1);
      disp_valid = 1'b1; disp_opcode = op; disp_offset = off; disp_dw0 = dw0;
      @(negedge clk);
      disp_valid = 1'b0;
      while (!done && cyc < 100) begin
         if (rd_req_valid) begin
            if (nreq < en)
               chk(rd_req_addr == ea[nreq], "R2", "read address", 64'(rd_req_addr), 64'(ea[nreq]));
            else
               chk(1'b0, "R2", "unexpected read", 64'(rd_req_addr), 64'd0);
            nreq++;
         end
         if (upd_valid) begin
            gotupd = 1; gidx = upd_index; gent = upd_entry; gdev = upd_is_dev;
         end
         if (done_valid) begin
            done = 1; gok = done_ok;
         end else begin
            chk(disp_ready == 1'b0, "R9", "ready while busy", 64'(disp_ready), 64'd0);
            @(negedge clk);
            cyc++;
         end
      end
      chk(done, "R9", "completion seen", 64'(done), 64'd1);
      chk(cyc == edone, rq, "completion cycle", 64'(cyc), 64'(edone));
      chk(nreq == en, (en == 0) ? "R8" : "R2", "read count", 64'(nreq), 64'(en));
      chk(gok == eok, eok ? rq : "R7", "done_ok", 64'(gok), 64'(eok));
      chk(gotupd == eupd, rq, "update issued", 64'(gotupd), 64'(eupd));
      if (eupd && gotupd) begin
         chk(gdev == edev, rq, "update table select", 64'(gdev), 64'(edev));
         chk(gidx == eidx, rq, "update index", 64'(gidx), 64'(eidx));
         chk(gent == eent, rq, "update entry", gent, eent);
      end
      @(negedge clk);
      chk(disp_ready == 1'b1, "R9", "ready after completion", 64'(disp_ready), 64'd1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle state under and after reset
      chk(disp_ready == 1'b1, "R1", "ready in reset", 64'(disp_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(disp_ready == 1'b1, "R1", "ready after reset", 64'(disp_ready), 64'd1);
      chk(rd_req_valid == 1'b0, "R1", "no read after reset", 64'(rd_req_valid), 64'd0);
      chk(upd_valid == 1'b0, "R1", "no update after reset", 64'(upd_valid), 64'd0);
      chk(done_valid == 1'b0, "R1", "no done after reset", 64'(done_valid), 64'd0);

      // R3: collection mapping with junk above the target field
      run_cmd("R3", 8'h09, 20'h00100, 64'hFFFF_FFFF_FFFF_FF09, 64'hDEAD, 0,
              {1'b1, 31'h5A5A_1234, 16'd3, 16'd7}, 0, 0);
      // R5: exactly at both limits is accepted
      run_cmd("R5", 8'h09, 20'h00140, 64'h9, 64'h0, 0, {1'b1, 31'h0, 16'd4, 16'd100}, 0, 2);
      // R5: collection ID one past the limit
      run_cmd("R5", 8'h09, 20'h00160, 64'h9, 64'h0, 0, {1'b1, 31'h0, 16'd1, 16'd101}, 0, 1);
      // R5: target one past the CPU count
      run_cmd("R5", 8'h09, 20'h00180, 64'h9, 64'h0, 0, {1'b1, 31'h0, 16'd5, 16'd2}, 0, 0);
      // R3: cleared valid flag gives a zero entry
      run_cmd("R3", 8'h09, 20'h001A0, 64'h9, 64'h0, 0, {1'b0, 31'h7FFF_0000, 16'd2, 16'd5}, 0, 1);
      // R4: device mapping, junk in ignored bits, fields at limits
      run_cmd("R4", 8'h08, 20'h00200, {32'd1000, 32'hCAFE_0008},
              {59'h7FF_FFFF_FFFF_FFE, 5'd20}, 0,
              {1'b1, 11'h7FF, 44'hABC_DE12_3456, 8'hA5}, 0, 1);
      // R6: device ID one past the limit
      run_cmd("R6", 8'h08, 20'h00220, {32'd1001, 32'h8}, 64'd3, 0,
              {1'b1, 11'h0, 44'h1, 8'h0}, 0, 0);
      // R6: size one past the supported bits
      run_cmd("R6", 8'h08, 20'h00240, {32'd12, 32'h8}, 64'd21, 0,
              {1'b1, 11'h0, 44'h2, 8'h0}, 0, 2);
      // R4: cleared valid flag gives a zero entry
      run_cmd("R4", 8'h08, 20'h00260, {32'd9, 32'h8}, 64'd4, 0,
              {1'b0, 11'h0, 44'hFFF, 8'hFF}, 0, 0);
      // R7: error on the first device fetch stops after one read
      run_cmd("R7", 8'h08, 20'h00280, {32'd9, 32'h8}, 64'd4, 1,
              {1'b1, 11'h0, 44'h5, 8'h0}, 0, 1);
      // R7: error on the second device fetch
      run_cmd("R7", 8'h08, 20'h002A0, {32'd9, 32'h8}, 64'd4, 0,
              {1'b1, 11'h0, 44'h5, 8'h0}, 1, 0);
      // R7: error on the collection fetch
      run_cmd("R7", 8'h09, 20'h002C0, 64'h9, 64'h0, 0, {1'b1, 31'h0, 16'd1, 16'd1}, 1, 2);
      // R8: other opcodes finish at once
      run_cmd("R8", 8'h05, 20'h002E0, 64'h5, 64'h0, 0, 64'h0, 0, 0);
      run_cmd("R8", 8'h0A, 20'h00300, 64'hA, 64'h0, 0, 64'h0, 0, 0);
      // R2: addresses wrap at the top of the offset space
      run_cmd("R2", 8'h08, 20'hFFFF0, {32'd77, 32'h8}, 64'd6, 0,
              {1'b1, 11'h0, 44'h123, 8'h0}, 0, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule